// File: doc/BRIEF.md
# General-Purpose I/O Port with Set/Clear Output Control

This block is a parameterized general-purpose I/O port of 32 pins by default, reached through a simple memory-mapped register bus. Software sets each pin's direction through a direction register. A pin whose direction bit is 1 is an input. A pin whose direction bit is 0 is an output, and its output enable is asserted at the pad.

The output latch has no plain write path. Bits are raised through a write-one-to-set register and lowered through a write-one-to-clear register. Software can therefore change one pin without a read-modify-write sequence, and no other pin is disturbed.

The pad level is always sampled through a two-flop synchronizer into an input register. This holds whether the pin is an input or is driven by the port itself. A read of the input register taken just after an output write can therefore still show the old level.

The pads are modelled as three vectors: an output vector, an output-enable vector and an input vector. These connect to tri-state I/O cells outside the block.

Top module: `gpio_sc_port`

## Requirements
- R1: When reset is released, every direction bit is 1, so `pad_oe` is all zeros, and the output latch and `pad_out` are all zeros.
- R2: A write to the direction register at byte offset 0x10 loads it, and a read at 0x10 returns it. Every `pad_oe` bit equals the inverse of its direction bit from the cycle after the write.
- R3: A write to the set register at offset 0x18 sets each output latch bit whose write-data bit is 1 and leaves the other bits unchanged, visible on `pad_out` in the cycle after the write.
- R4: A write to the clear register at offset 0x1C clears each output latch bit whose write-data bit is 1 and leaves the other bits unchanged, visible on `pad_out` in the cycle after the write.
- R5: A read at offset 0x14, 0x18 or 0x1C returns the current output latch value.
- R6: A read at offset 0x20 returns the pad input level as it was two clock edges earlier, whatever the pin's direction.
- R7: Writes to offsets 0x14 and 0x20, and writes to any unmapped offset, change neither the direction register nor the output latch. Reads at unmapped offsets return zero.
- R8: A cycle with `bus_we` high and `bus_en` low changes no register.
- R9: `pad_out` carries the output latch on every pin, whether or not that pin's output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Level seen at each pad |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Output enable per pad, 1 = driven |

## Verification
The hardest case to reach from the ports is the lag between an output write and the input register. The bench has to catch the window in which a pin configured as an output already drives its new level while a read at 0x20 still returns the old one. The stimulus loops `pad_out` back onto `pad_in`, sets a bit through the set register and reads the input register after one clock edge and again after a second. It expects the old level on the first read and the new level on the second. A further test changes `pad_in` directly on a pin configured as an output, to show that the sampling does not depend on direction.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_IN    = 8'h20;

  typedef enum logic [2:0] {
    RSEL_NONE = 3'd0,
    RSEL_DIR  = 3'd1,
    RSEL_OUT  = 3'd2,
    RSEL_IN   = 3'd3
  } rd_sel_e;

  typedef struct packed {
    logic dir_wr;
    logic set_wr;
    logic clr_wr;
  } wr_stb_t;

  // Next output latch value from set and clear masks; clear dominates.
  function automatic logic [31:0] f_apply_sc(input logic [31:0] cur,
                                             input logic [31:0] set_m,
                                             input logic [31:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  // Output enable is active for pins whose direction bit is 0.
  function automatic logic [31:0] f_oe_from_dir(input logic [31:0] dir);
    return ~dir;
  endfunction

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
(
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_stb_t           wr_stb,
  output rd_sel_e           rd_sel
);

  logic do_wr;
  assign do_wr = bus_en & bus_we;

  always_comb begin
    wr_stb = '0;
    rd_sel = RSEL_NONE;
    unique case (bus_addr)
      OFS_DIR: begin
        wr_stb.dir_wr = do_wr;
        rd_sel        = RSEL_DIR;
      end
      OFS_OUT: rd_sel = RSEL_OUT;
      OFS_SET: begin
        wr_stb.set_wr = do_wr;
        rd_sel        = RSEL_OUT;
      end
      OFS_CLR: begin
        wr_stb.clr_wr = do_wr;
        rd_sel        = RSEL_OUT;
      end
      OFS_IN:  rd_sel = RSEL_IN;
      default: rd_sel = RSEL_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
  import gpio_sc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_stb_t      wr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q
);

  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;
  logic [W-1:0] out_nxt;
  logic [31:0]  cur_ext;
  logic [31:0]  set_ext;
  logic [31:0]  clr_ext;
  logic [31:0]  nxt_ext;

  assign set_mask = wr_stb.set_wr ? wdata : '0;
  assign clr_mask = wr_stb.clr_wr ? wdata : '0;

  assign cur_ext = 32'(out_q);
  assign set_ext = 32'(set_mask);
  assign clr_ext = 32'(clr_mask);
  assign nxt_ext = f_apply_sc(cur_ext, set_ext, clr_ext);
  assign out_nxt = nxt_ext[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
    end else if (wr_stb.dir_wr) begin
      dir_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (wr_stb.set_wr || wr_stb.clr_wr) begin
      out_q <= out_nxt;
    end
  end

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-2:0], d[b]};
      end
    end
    assign q[b] = chain[LAST];
  end

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpio_sc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);

  wr_stb_t      wr_stb;
  rd_sel_e      rd_sel;
  logic [W-1:0] dir_q;
  logic [W-1:0] out_q;
  logic [W-1:0] in_q;
  logic [31:0]  oe_ext;

  // Named event wires for the checker.
  logic dir_stb;
  logic set_stb;
  logic clr_stb;
  assign dir_stb = wr_stb.dir_wr;
  assign set_stb = wr_stb.set_wr;
  assign clr_stb = wr_stb.clr_wr;

  gpio_sc_decode u_decode (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_stb   (wr_stb),
    .rd_sel   (rd_sel)
  );

  gpio_sc_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .out_q  (out_q)
  );

  gpio_sc_sync #(.W(W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_q)
  );

  assign oe_ext  = f_oe_from_dir(32'(dir_q));
  assign pad_oe  = oe_ext[W-1:0];
  assign pad_out = out_q;

  always_comb begin
    unique case (rd_sel)
      RSEL_DIR: bus_rdata = dir_q;
      RSEL_OUT: bus_rdata = out_q;
      RSEL_IN:  bus_rdata = in_q;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_sc_checker.sv
module gpio_sc_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dir_stb,
  input logic         set_stb,
  input logic         clr_stb,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] in_q
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0));

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_stb |=> (pad_oe == ~$past(bus_wdata)));

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

  p_set_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((pad_out & $past(bus_wdata)) == '0));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb || clr_stb) |=> $stable(pad_out));

  p_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_stb |=> $stable(pad_oe));

  p_sync_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (in_q == $past(pad_in, 2)));

endmodule

bind gpio_sc_port gpio_sc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_stb   (dir_stb),
  .set_stb   (set_stb),
  .clr_stb   (clr_stb),
  .bus_wdata (bus_wdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .in_q      (in_q)
);

// File: tb/gpio_sc_port_bench.sv
module gpio_sc_port_bench;

  localparam int  W        = 32;
  localparam time CLK_PER  = 10ns;
  localparam int  WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_en;
  logic         bus_we;
  logic [7:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in;
  logic [W-1:0] pad_out;
  logic [W-1:0] pad_oe;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] exp_dir;
  logic [W-1:0] exp_out;

  always #(CLK_PER/2) clk = ~clk;

  gpio_sc_port #(.W(W)) u_gpio_sc_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge; the write lands at the next rising edge.
  task automatic bus_write(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [W-1:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [W-1:0] r;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_dir = '1; exp_out = '0;
    check("R1", "pad_oe after reset", pad_oe, '0);
    check("R1", "pad_out after reset", pad_out, '0);
    bus_read(8'h10, r);
    check("R1", "direction after reset", r, '1);
  endtask

  task automatic t_direction;
    logic [W-1:0] r;
    bus_write(8'h10, 32'h0F0F_00FF);
    exp_dir = 32'h0F0F_00FF;
    check("R2", "pad_oe after dir write", pad_oe, ~exp_dir);
    bus_read(8'h10, r);
    check("R2", "dir readback", r, exp_dir);
    bus_write(8'h10, 32'hFFFF_0000);
    exp_dir = 32'hFFFF_0000;
    check("R2", "pad_oe second pattern", pad_oe, 32'h0000_FFFF);
  endtask

  task automatic t_set;
    bus_write(8'h18, 32'h8000_0011);
    exp_out = exp_out | 32'h8000_0011;
    check("R3", "set first mask", pad_out, exp_out);
    bus_write(8'h18, 32'h0000_0300);
    exp_out = exp_out | 32'h0000_0300;
    check("R3", "set keeps others", pad_out, exp_out);
    bus_write(8'h18, 32'h0);
    check("R3", "zero set mask no change", pad_out, exp_out);
  endtask

  task automatic t_clear;
    bus_write(8'h1C, 32'h0000_0101);
    exp_out = exp_out & ~32'h0000_0101;
    check("R4", "clear mask", pad_out, exp_out);
    bus_write(8'h1C, 32'h0000_0000);
    check("R4", "zero clear mask no change", pad_out, exp_out);
  endtask

  task automatic t_readback;
    logic [W-1:0] r;
    bus_read(8'h14, r); check("R5", "read 0x14", r, exp_out);
    bus_read(8'h18, r); check("R5", "read 0x18", r, exp_out);
    bus_read(8'h1C, r); check("R5", "read 0x1C", r, exp_out);
  endtask

  task automatic t_ignored;
    logic [W-1:0] r;
    bus_write(8'h14, 32'h1234_5678);
    check("R7", "write 0x14 ignored", pad_out, exp_out);
    bus_write(8'h20, 32'hFFFF_FFFF);
    check("R7", "write 0x20 out ignored", pad_out, exp_out);
    check("R7", "write 0x20 oe ignored", pad_oe, ~exp_dir);
    bus_write(8'h24, 32'h0);
    check("R7", "unmapped write dir", pad_oe, ~exp_dir);
    bus_read(8'h0C, r); check("R7", "unmapped read 0x0C", r, '0);
    bus_read(8'h11, r); check("R7", "unaligned read 0x11", r, '0);
  endtask

  task automatic t_bus_idle;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b1; bus_addr = 8'h18; bus_wdata = '1;
    @(negedge clk);
    bus_addr = 8'h10; bus_wdata = '0;
    @(negedge clk);
    bus_we = 1'b0;
    check("R8", "disabled set ignored", pad_out, exp_out);
    check("R8", "disabled dir ignored", pad_oe, ~exp_dir);
  endtask

  task automatic t_pad_out_all;
    bus_write(8'h10, 32'hFFFF_FFFF);
    exp_dir = '1;
    bus_write(8'h18, 32'h00A0_0000);
    exp_out = exp_out | 32'h00A0_0000;
    check("R9", "pad_out while all inputs", pad_out, exp_out);
    check("R9", "pad_oe all off", pad_oe, '0);
  endtask

  task automatic t_input_sync;
    logic [W-1:0] r;
    @(negedge clk);
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_read(8'h20, r); check("R6", "input after one edge old", r, 32'h0);
    @(negedge clk);
    bus_read(8'h20, r); check("R6", "input after two edges", r, 32'hDEAD_BEEF);
    // Pin 4 as output, looped back: set it and watch the lag.
    bus_write(8'h10, ~32'h0000_0010);
    exp_dir = ~32'h0000_0010;
    bus_write(8'h1C, 32'h0000_0010);
    exp_out = exp_out & ~32'h0000_0010;
    pad_in = pad_out;
    repeat (3) @(negedge clk);
    bus_write(8'h18, 32'h0000_0010);
    exp_out = exp_out | 32'h0000_0010;
    pad_in = pad_out;
    bus_read(8'h20, r); check("R6", "looped output not yet seen", r[4], 1'b0);
    @(negedge clk);
    bus_read(8'h20, r); check("R6", "looped output one edge", r[4], 1'b0);
    @(negedge clk);
    bus_read(8'h20, r); check("R6", "looped output two edges", r[4], 1'b1);
    // Pad forced low against a driven-high output pin: input still follows pad.
    pad_in[4] = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(8'h20, r); check("R6", "input follows pad on output pin", r[4], 1'b0);
    check("R9", "pad_out unchanged by pad_in", pad_out, exp_out);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_direction();
    t_set();
    t_clear();
    t_readback();
    t_ignored();
    t_bus_idle();
    t_pad_out_all();
    t_input_sync();
    finish_run();
  end

endmodule